// File: doc/BRIEF.md
# Programmable Clock Channel Divider with Phase Slip

This block is one output channel of a clock distribution tree. It divides a fast input clock by a programmable 12-bit ratio and always produces a 50% duty cycle. For odd ratios the output transitions on input falling edges, and a ratio of 1 reproduces the input clock. A coarse digital delay can shift the divided clock later by a number of input half-cycles, clamped to 17.

The phase can be adjusted in two ways. An accepted sync pulse restarts the divider at the beginning of a period and loads a new ratio. A slip request retards the phase by holding the divider for one input cycle. In multislip mode each slip event holds the divider for a programmed number of cycles, and an accepted sync also triggers that many holds. Slip requests that arrive while earlier holds are still outstanding are added to a pending count, so none are lost.

All logic runs on the rising edge of the input clock. The output is taken from a registered half-cycle pattern that the input clock level selects between.

Top module: `clkdiv_slip`

## Requirements
- R1: The ratio is the 12-bit value {div_hi, div_lo}. An even ratio N from 2 to 4094 gives a period of N input cycles, high for N/2 cycles and then low for N/2 cycles.
- R2: An odd ratio N of 1, 3 or 5 gives a period of N input cycles that is high for exactly N input half-cycles, so the falling transition occurs on an input falling edge. Ratio 1 reproduces the input clock.
- R3: A ratio of 0 behaves as 2. An odd ratio above 5 behaves as the even value one below it.
- R4: At each rising edge where en or rst_n is low, the output goes low for the whole following cycle and stays low while disabled. Any pending slips are discarded.
- R5: The ratio is captured only on the first enabled edge and on an accepted sync. Changes at any other time have no effect on the output. With zero delay, a new period starts (output high) in the cycle after the capturing edge.
- R6: A sync_req sampled high with sync_en set while the channel runs restarts the period. The cycle after that edge is the first high cycle of a new period, and the ratio is reloaded.
- R7: With sync_en clear, sync_req has no effect on the phase or the ratio.
- R8: With slip_en set and mslip_en clear, each slip_req pulse sampled at edge n makes the divider repeat its state in cycle n+1, which stretches one period by one input cycle.
- R9: With slip_en clear, slip_req has no effect.
- R10: With slip_en and mslip_en set, each slip_req adds mslip_cnt held cycles. A count of 0 adds none.
- R11: Slip holds requested while others are outstanding are accumulated, not dropped. The pending total saturates at 65535.
- R12: An accepted sync with slip_en and mslip_en set restarts the period, discards earlier pending holds and then applies mslip_cnt held cycles.
- R13: The output is delayed by d input half-cycles, where d is coarse clamped to 17. Changes to coarse act at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable |
| sync_en | input | 1 | Accept sync pulses |
| slip_en | input | 1 | Accept slip events |
| mslip_en | input | 1 | Repeat each slip event mslip_cnt times |
| div_lo | input | 8 | Ratio bits 7:0 |
| div_hi | input | 4 | Ratio bits 11:8 |
| coarse | input | 5 | Coarse delay in half input cycles |
| mslip_cnt | input | 12 | Holds per multislip event |
| sync_req | input | 1 | Sync pulse, one clock wide |
| slip_req | input | 1 | Slip pulse, one clock wide |
| clk_out | output | 1 | Divided, delayed clock |

## Verification
Every control input is sampled at a rising edge. Its effect first appears, at zero delay, in the high half of the next input cycle, and d half-cycles later when a coarse delay is set. Coarse changes act in the same half-cycle. The bench advances a reference model once per rising edge using the inputs held across that edge. It then samples clk_out 2.5 ns into the high half and again 2.5 ns into the low half, and changes inputs only after the second sample. Duty checks count high half-cycles over exactly one settled period.

// File: rtl/clkdiv_slip.sv
module clkdiv_slip #(
  parameter int DW   = 12,
  parameter int CW   = 5,
  parameter int MAXD = 17,
  parameter int MW   = 12,
  parameter int PW   = 16
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync_en,
  input  logic          slip_en,
  input  logic          mslip_en,
  input  logic [7:0]    div_lo,
  input  logic [DW-9:0] div_hi,
  input  logic [CW-1:0] coarse,
  input  logic [MW-1:0] mslip_cnt,
  input  logic          sync_req,
  input  logic          slip_req,
  output logic          clk_out
);
  localparam int VW = MAXD + 2;
  localparam int IW = $clog2(VW);
  localparam int SW = PW + 2;
  localparam logic [CW-1:0] DMAX = CW'(MAXD);
  localparam logic [SW-1:0] PMAX = SW'({PW{1'b1}});

  logic [DW-1:0] div_raw, div_ok, r_act, r_use, cnt, cnt_nx, cnt_wrap;
  logic [PW-1:0] pend, pend_nx;
  logic [SW-1:0] add_slip, add_sync, pend_sum;
  logic [VW-1:0] wave;
  logic [CW-1:0] dly;
  logic [IW-1:0] ia, ib;
  logic run, load, sync_hit, hold, e0, e1;

  assign div_raw = {div_hi, div_lo};

  always_comb begin
    div_ok = div_raw;
    if (div_raw == '0) div_ok = DW'(2);
    else if (div_raw[0] && div_raw > DW'(5)) div_ok = {div_raw[DW-1:1], 1'b0};
  end

  assign sync_hit = run && sync_req && sync_en;
  assign load     = !run || sync_hit;
  assign hold     = !load && (pend != '0);
  assign r_use    = load ? div_ok : r_act;
  assign cnt_wrap = (cnt == r_act - DW'(1)) ? '0 : cnt + DW'(1);
  assign cnt_nx   = load ? '0 : (hold ? cnt : cnt_wrap);
  assign e0       = {cnt_nx, 1'b0} < {1'b0, r_use};
  assign e1       = {cnt_nx, 1'b1} < {1'b0, r_use};

  assign add_slip = (slip_req && slip_en) ? (mslip_en ? SW'(mslip_cnt) : SW'(1)) : '0;
  assign add_sync = (sync_hit && slip_en && mslip_en) ? SW'(mslip_cnt) : '0;
  assign pend_sum = (load ? '0 : SW'(pend) - SW'(hold)) + add_slip + add_sync;
  assign pend_nx  = (pend_sum > PMAX) ? '1 : pend_sum[PW-1:0];

  always_ff @(posedge clk_in) begin
    if (!rst_n || !en) begin
      run  <= 1'b0;
      cnt  <= '0;
      pend <= '0;
      wave <= '0;
    end else begin
      run  <= 1'b1;
      cnt  <= cnt_nx;
      pend <= pend_nx;
      wave <= {wave[VW-3:0], e0, e1};
    end
  end

  always_ff @(posedge clk_in) begin
    if (!rst_n) r_act <= DW'(2);
    else if (en && load) r_act <= div_ok;
  end

  assign dly     = (coarse > DMAX) ? DMAX : coarse;
  assign ia      = IW'(dly);
  assign ib      = ia + IW'(1);
  assign clk_out = clk_in ? wave[ib] : wave[ia];

  p_off_low_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    !en |=> (!clk_out && pend == '0 && !run));
  p_cnt_range_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    run |-> (cnt < r_act));
  p_ratio_legal_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    run |-> (r_act != '0 && (!r_act[0] || r_act <= DW'(5))));
  p_ratio_kept_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run && en && !(sync_req && sync_en)) |=> $stable(r_act));
  p_sync_restart_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (en && sync_hit) |=> (cnt == '0 && wave[1]));
  p_slip_hold_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (en && run && !sync_hit && pend != '0) |=> (cnt == $past(cnt)));
endmodule

// File: tb/clkdiv_slip_test.sv
`timescale 1ns/1ps
module clkdiv_slip_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sync_en = 1'b0, slip_en = 1'b0, mslip_en = 1'b0;
  logic [7:0] div_lo = 8'd4;
  logic [3:0] div_hi = 4'd0;
  logic [4:0] coarse = 5'd0;
  logic [11:0] mslip_cnt = 12'd0;
  logic sync_req = 1'b0, slip_req = 1'b0;
  logic clk_out;

  int total = 0, bad = 0, hi_cnt = 0;
  string tag = "R4";

  int unsigned m_r = 2, m_ph = 0, m_pend = 0;
  bit m_run = 0;
  logic [63:0] m_h = '0;

  clkdiv_slip uut (
    .clk_in(clk), .rst_n(rst_n), .en(en), .sync_en(sync_en), .slip_en(slip_en),
    .mslip_en(mslip_en), .div_lo(div_lo), .div_hi(div_hi), .coarse(coarse),
    .mslip_cnt(mslip_cnt), .sync_req(sync_req), .slip_req(slip_req), .clk_out(clk_out)
  );

  always #5 clk = ~clk;

  function automatic int unsigned norm(int unsigned v);
    if (v == 0) return 2;
    if ((v % 2) == 1 && v > 5) return v - 1;
    return v;
  endfunction

  function automatic int unsigned clampd(int unsigned c);
    return (c > 17) ? 17 : c;
  endfunction

  task automatic chk(bit got, bit exp, string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: clk_out=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit hit, ld;
    int unsigned add;
    if (!rst_n || !en) begin
      m_run = 0; m_pend = 0; m_ph = 0; m_h = '0;
      return;
    end
    hit = m_run && sync_req && sync_en;
    ld = !m_run || hit;
    if (ld) begin
      m_r = norm({div_hi, div_lo}); m_ph = 0; m_pend = 0; m_run = 1;
    end else if (m_pend > 0) m_pend--;
    else m_ph = (m_ph + 1 == m_r) ? 0 : m_ph + 1;
    add = 0;
    if (slip_req && slip_en) add += mslip_en ? mslip_cnt : 1;
    if (hit && slip_en && mslip_en) add += mslip_cnt;
    m_pend = (m_pend + add > 65535) ? 65535 : m_pend + add;
    m_h = {m_h[61:0], (2*m_ph < m_r), (2*m_ph + 1 < m_r)};
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2.5;
    chk(clk_out, m_h[clampd(coarse) + 1], tag);
    hi_cnt += int'(clk_out);
    #5;
    chk(clk_out, m_h[clampd(coarse)], tag);
    hi_cnt += int'(clk_out);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_div(int unsigned v);
    {div_hi, div_lo} = 12'(v);
  endtask

  task automatic reload(int unsigned v);
    set_div(v); en = 1'b0; cyc(); en = 1'b1;
  endtask

  task automatic duty(int unsigned v, string req);
    int unsigned r;
    r = norm(v);
    reload(v);
    run(2*r + 20);
    hi_cnt = 0;
    run(r);
    total++;
    if (hi_cnt != r) begin
      bad++;
      $display("FAIL %s: high halves=%0d expected=%0d ratio=%0d", req, hi_cnt, r, v);
    end
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1; cyc(); sync_req = 1'b0;
  endtask

  task automatic pulse_slip();
    slip_req = 1'b1; cyc(); slip_req = 1'b0;
  endtask

  function automatic int unsigned pick_div();
    case ($urandom % 10)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 5;
      5: return 0;  6: return 7;  7: return 9;  8: return 2 * (1 + $urandom % 20);
      default: return 6;
    endcase
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not finish, got=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tag = "R4";
    run(3);
    total++;
    if (clk_out !== 1'b0) begin
      bad++; $display("FAIL R4: reset clk_out=%0b expected=0", clk_out);
    end
    rst_n = 1'b1;
    run(2);

    tag = "R1"; en = 1'b1;
    duty(4, "R1"); duty(2, "R1"); duty(10, "R1"); duty(4094, "R1");
    tag = "R2";
    duty(3, "R2"); duty(5, "R2"); duty(1, "R2");
    tag = "R3";
    duty(0, "R3"); duty(7, "R3"); duty(11, "R3");

    tag = "R5"; reload(4); run(10);
    set_div(6); run(20);
    sync_en = 1'b1; pulse_sync(); run(20);
    reload(3); run(9);

    tag = "R6"; set_div(8); run(5); pulse_sync(); run(3); pulse_sync(); run(25);
    set_div(5); pulse_sync(); run(12);

    tag = "R7"; sync_en = 1'b0; set_div(2); run(3); pulse_sync(); run(4); pulse_sync(); run(15);

    tag = "R8"; reload(6); run(7); slip_en = 1'b1; pulse_slip(); run(8); pulse_slip(); run(2); pulse_slip(); run(15);
    reload(3); run(4); pulse_slip(); run(10);

    tag = "R9"; slip_en = 1'b0; pulse_slip(); run(6); mslip_en = 1'b1; mslip_cnt = 12'd3; pulse_slip(); run(10);

    tag = "R10"; slip_en = 1'b1; pulse_slip(); run(12); mslip_cnt = 12'd0; pulse_slip(); run(8);
    mslip_cnt = 12'd5; reload(5); run(3); pulse_slip(); run(20);

    tag = "R11"; mslip_cnt = 12'd4; pulse_slip(); pulse_slip(); run(1); pulse_slip(); run(20);
    mslip_cnt = 12'hFFF;
    for (int i = 0; i < 18; i++) pulse_slip();
    run(50);
    tag = "R4"; en = 1'b0; run(4); en = 1'b1; mslip_cnt = 12'd2; run(12);

    tag = "R12"; sync_en = 1'b1; pulse_slip(); run(1); pulse_sync(); run(20);
    mslip_en = 1'b0; pulse_sync(); run(10); mslip_en = 1'b1;

    tag = "R13"; slip_en = 1'b0; reload(3);
    coarse = 5'd1; run(8); coarse = 5'd5; run(8); coarse = 5'd17; run(12);
    coarse = 5'd20; run(8); coarse = 5'd31; run(8);
    reload(4); coarse = 5'd2; run(10); coarse = 5'd0; run(4);

    tag = "R1";
    for (int i = 0; i < 20000; i++) begin
      sync_req  = ($urandom % 40) == 0;
      slip_req  = ($urandom % 25) == 0;
      if (($urandom % 300) == 0) en = ~en;
      else if (!en && ($urandom % 10) == 0) en = 1'b1;
      if (($urandom % 50) == 0) set_div(pick_div());
      if (($urandom % 100) == 0) begin
        sync_en = $urandom; slip_en = $urandom; mslip_en = $urandom;
        mslip_cnt = 12'($urandom % 5);
      end
      if (($urandom % 150) == 0) coarse = 5'($urandom);
      cyc();
    end
    sync_req = 1'b0; slip_req = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule